// File: doc/BRIEF.md
# Line-Undervoltage Power-Mode Sequencer

This block decides which power mode a switching controller sits in. It reads five comparator flags that are already synchronised to the system clock. Three of them compare a scaled copy of the input line against a low reset level, a standby level and a higher enable level. The other two compare the local supply against its turn-on and turn-off levels. Each comparator already has its own analog hysteresis. The block adds the digital deglitch windows, the hold latches and the ordering rules on top of those flags.

The block moves through four modes. In shutdown, nothing runs. In standby, the line is present but the converter is not yet allowed to switch. In arming, the hysteresis pull-down current source is on and a fixed start delay counts down. In run, switching is enabled. Standby is held by a latch that a filtered standby flag sets and the reset flag clears. The run path needs both a latched supply-ready condition and a filtered line-enable condition. A loss of either one drops the controller back to the low-quiescent standby mode. A loss of the line-reset flag sends it all the way to shutdown.

Top module: `pmseq_uvlo_top`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `mode_o` is 0 (shutdown), `low_iq_o` is 1, and `hyst_src_en_o` and `sw_en_o` are 0.
- R2: Shutdown is left only after `line_gt_stby_i` has been high on STBY_FILT_CYC consecutive clock edges. A low sample restarts the count, so a shorter pulse leaves the mode at 0.
- R3: Once standby is latched, it holds while `line_gt_rst_i` stays high, even if `line_gt_stby_i` falls. A single low sample of `line_gt_rst_i` returns `mode_o` to 0 within two cycles, from any mode, and this overrides a simultaneous standby set.
- R4: The line-enable condition counts only after `line_gt_en_i` has been high on EN_FILT_CYC consecutive edges. A shorter pulse leaves the mode at 1 (standby).
- R5: Supply-ready is set by a high sample of `vdd_gt_on_i` and cleared only by a low sample of `vdd_gt_off_i`. While it is clear, the block cannot leave standby, even if the off flag is high again.
- R6: When supply-ready and line-enable both hold in standby, `mode_o` becomes 2 (arming) with `hyst_src_en_o` high and `sw_en_o` low. It stays there for exactly START_DLY_CYC cycles and then becomes 3 (run) with `sw_en_o` high.
- R7: A low sample of `vdd_gt_off_i` during arming or run drops `sw_en_o` and `hyst_src_en_o` and returns `mode_o` to 1 with `low_iq_o` high, within two cycles.
- R8: Loss of the filtered line-enable condition during arming or run returns `mode_o` to 1 and turns off the hysteresis source.
- R9: All outputs are registered. `low_iq_o` is high exactly in modes 0 and 1, `hyst_src_en_o` exactly in modes 2 and 3, and `sw_en_o` exactly in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_gt_rst_i | input | 1 | Line divider above the reset level |
| line_gt_stby_i | input | 1 | Line divider above the standby level |
| line_gt_en_i | input | 1 | Line divider above the enable level |
| vdd_gt_on_i | input | 1 | Supply above its turn-on level |
| vdd_gt_off_i | input | 1 | Supply above its turn-off level |
| mode_o | output | 2 | Mode: 0 shutdown, 1 standby, 2 arming, 3 run |
| low_iq_o | output | 1 | Low-quiescent indication |
| hyst_src_en_o | output | 1 | Enable for the line hysteresis current source |
| sw_en_o | output | 1 | Switching enable |

## Verification
The bench builds the block with a standby window of 4 cycles, a line-enable window of 3 cycles and a start delay of 6 cycles. With these short values, pulses that fall one cycle short of a window, window restarts, and the full arming countdown all fit into a few dozen cycles. Every sequence can therefore be followed edge by edge against a behavioural model. The short delay also lets supply and line drops be placed mid-countdown as well as during run.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;
  typedef enum logic [1:0] {
    PM_SHDN = 2'd0,
    PM_STBY = 2'd1,
    PM_ARM  = 2'd2,
    PM_RUN  = 2'd3
  } pm_mode_e;
endpackage

// File: rtl/pmseq_deglitch.sv
// Qualifies a level: the output rises only after LEN consecutive high
// samples and falls on the first low sample.
module pmseq_deglitch #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (LEN <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) dout <= 1'b0;
        else     dout <= din;
      end
    end else begin : g_count
      localparam int unsigned CW = $clog2(LEN);
      localparam logic [CW-1:0] LAST = CW'(LEN - 1);
      logic [CW-1:0] run_cnt;
      always_ff @(posedge clk) begin
        if (rst || !din) begin
          run_cnt <= '0;
          dout    <= 1'b0;
        end else if (run_cnt == LAST) begin
          dout    <= 1'b1;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pmseq_sr_hold.sv
// Clocked set/clear hold element; CLR_WINS picks the priority.
module pmseq_sr_hold #(
  parameter bit CLR_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  generate
    if (CLR_WINS) begin : g_clr_pri
      always_ff @(posedge clk) begin
        if (rst || clr_i) q <= 1'b0;
        else if (set_i)   q <= 1'b1;
      end
    end else begin : g_set_pri
      always_ff @(posedge clk) begin
        if (rst)         q <= 1'b0;
        else if (set_i)  q <= 1'b1;
        else if (clr_i)  q <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/pmseq_mode_fsm.sv
module pmseq_mode_fsm
  import pmseq_pkg::*;
#(
  parameter int unsigned START_DLY = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stby_held,
  input  logic       supply_ok,
  input  logic       line_ok,
  output logic [1:0] mode_o,
  output logic       low_iq_o,
  output logic       hyst_en_o,
  output logic       sw_en_o
);
  localparam int unsigned DW = (START_DLY < 2) ? 1 : $clog2(START_DLY);
  localparam logic [DW-1:0] DLY_LAST = DW'((START_DLY < 1) ? 0 : START_DLY - 1);

  pm_mode_e      st, st_nxt;
  logic [DW-1:0] dly, dly_nxt;
  logic          go;

  assign go = supply_ok && line_ok;

  always_comb begin
    st_nxt  = st;
    dly_nxt = '0;
    if (!stby_held) begin
      st_nxt = PM_SHDN;
    end else begin
      unique case (st)
        PM_SHDN: st_nxt = PM_STBY;
        PM_STBY: if (go) st_nxt = PM_ARM;
        PM_ARM: begin
          if (!go)                  st_nxt = PM_STBY;
          else if (dly == DLY_LAST) st_nxt = PM_RUN;
          else                      dly_nxt = dly + 1'b1;
        end
        PM_RUN:  if (!go) st_nxt = PM_STBY;
        default: st_nxt = PM_SHDN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PM_SHDN;
      dly       <= '0;
      mode_o    <= PM_SHDN;
      low_iq_o  <= 1'b1;
      hyst_en_o <= 1'b0;
      sw_en_o   <= 1'b0;
    end else begin
      st        <= st_nxt;
      dly       <= dly_nxt;
      mode_o    <= st_nxt;
      low_iq_o  <= (st_nxt == PM_SHDN) || (st_nxt == PM_STBY);
      hyst_en_o <= (st_nxt == PM_ARM) || (st_nxt == PM_RUN);
      sw_en_o   <= (st_nxt == PM_RUN);
    end
  end
endmodule

// File: rtl/pmseq_uvlo_top.sv
module pmseq_uvlo_top #(
  parameter int unsigned STBY_FILT_CYC = 625,
  parameter int unsigned EN_FILT_CYC   = 125,
  parameter int unsigned START_DLY_CYC = 3125
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_gt_rst_i,
  input  logic       line_gt_stby_i,
  input  logic       line_gt_en_i,
  input  logic       vdd_gt_on_i,
  input  logic       vdd_gt_off_i,
  output logic [1:0] mode_o,
  output logic       low_iq_o,
  output logic       hyst_src_en_o,
  output logic       sw_en_o
);
  logic stby_q, line_ok, stby_held, supply_ok;

  pmseq_deglitch #(.LEN(STBY_FILT_CYC)) u_stby_flt (
    .clk(clk), .rst(rst), .din(line_gt_stby_i), .dout(stby_q));

  pmseq_deglitch #(.LEN(EN_FILT_CYC)) u_en_flt (
    .clk(clk), .rst(rst), .din(line_gt_en_i), .dout(line_ok));

  pmseq_sr_hold #(.CLR_WINS(1'b1)) u_stby_hold (
    .clk(clk), .rst(rst), .set_i(stby_q), .clr_i(!line_gt_rst_i), .q(stby_held));

  pmseq_sr_hold #(.CLR_WINS(1'b1)) u_vdd_hold (
    .clk(clk), .rst(rst), .set_i(vdd_gt_on_i), .clr_i(!vdd_gt_off_i), .q(supply_ok));

  pmseq_mode_fsm #(.START_DLY(START_DLY_CYC)) u_fsm (
    .clk(clk), .rst(rst),
    .stby_held(stby_held), .supply_ok(supply_ok), .line_ok(line_ok),
    .mode_o(mode_o), .low_iq_o(low_iq_o),
    .hyst_en_o(hyst_src_en_o), .sw_en_o(sw_en_o));
endmodule

// File: rtl/pmseq_uvlo_chk.sv
module pmseq_uvlo_chk (
  input logic       clk,
  input logic       rst,
  input logic       line_gt_rst_i,
  input logic       line_gt_en_i,
  input logic       vdd_gt_off_i,
  input logic [1:0] mode_o,
  input logic       low_iq_o,
  input logic       hyst_src_en_o,
  input logic       sw_en_o
);
  a_r6_sw_needs_hyst: assert property (@(posedge clk) disable iff (rst)
    sw_en_o |-> hyst_src_en_o);

  a_r6_run_after_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en_o) |-> $past(mode_o) == 2'd2);

  a_r3_reset_to_shdn: assert property (@(posedge clk) disable iff (rst)
    $past(!line_gt_rst_i, 2) |-> (mode_o == 2'd0));

  a_r7_supply_drop: assert property (@(posedge clk) disable iff (rst)
    $past(!vdd_gt_off_i, 2) |-> (!sw_en_o && !hyst_src_en_o && low_iq_o));

  a_r8_line_drop: assert property (@(posedge clk) disable iff (rst)
    $past(!line_gt_en_i, 2) |-> !hyst_src_en_o);

  a_r9_lowiq_excl: assert property (@(posedge clk) disable iff (rst)
    low_iq_o |-> (!hyst_src_en_o && !sw_en_o));
endmodule

bind pmseq_uvlo_top pmseq_uvlo_chk u_chk (
  .clk(clk), .rst(rst), .line_gt_rst_i(line_gt_rst_i),
  .line_gt_en_i(line_gt_en_i), .vdd_gt_off_i(vdd_gt_off_i),
  .mode_o(mode_o), .low_iq_o(low_iq_o),
  .hyst_src_en_o(hyst_src_en_o), .sw_en_o(sw_en_o));

// File: tb/test_pmseq_uvlo_top.sv
`timescale 1ns/1ps
module test_pmseq_uvlo_top;
  localparam int SF = 4;
  localparam int EF = 3;
  localparam int SD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_rst = 1'b0, l_stby = 1'b0, l_en = 1'b0, v_on = 1'b0, v_off = 1'b0;
  logic [1:0] mode;
  logic low_iq, hyst, sw;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  pmseq_uvlo_top #(.STBY_FILT_CYC(SF), .EN_FILT_CYC(EF), .START_DLY_CYC(SD)) i_pmseq_uvlo_top (
    .clk(clk), .rst(rst), .line_gt_rst_i(l_rst), .line_gt_stby_i(l_stby),
    .line_gt_en_i(l_en), .vdd_gt_on_i(v_on), .vdd_gt_off_i(v_off),
    .mode_o(mode), .low_iq_o(low_iq), .hyst_src_en_o(hyst), .sw_en_o(sw));

  // behavioural reference
  int m_scnt, m_ecnt, m_dly, m_st;
  bit m_sq, m_eq, m_slat, m_vok;

  always @(posedge clk) begin
    if (rst) begin
      m_scnt = 0; m_ecnt = 0; m_dly = 0; m_st = 0;
      m_sq = 0; m_eq = 0; m_slat = 0; m_vok = 0;
    end else begin
      if (!m_slat) begin m_st = 0; m_dly = 0; end
      else if (m_st == 0) m_st = 1;
      else if (m_st == 1) begin
        if (m_vok && m_eq) begin m_st = 2; m_dly = 0; end
      end else if (m_st == 2) begin
        if (!(m_vok && m_eq)) m_st = 1;
        else if (m_dly == SD - 1) m_st = 3;
        else m_dly++;
      end else if (!(m_vok && m_eq)) m_st = 1;
      if (!l_rst) m_slat = 0; else if (m_sq) m_slat = 1;
      if (!v_off) m_vok = 0; else if (v_on) m_vok = 1;
      if (!l_stby) begin m_scnt = 0; m_sq = 0; end
      else if (m_scnt == SF - 1) m_sq = 1; else m_scnt++;
      if (!l_en) begin m_ecnt = 0; m_eq = 0; end
      else if (m_ecnt == EF - 1) m_eq = 1; else m_ecnt++;
    end
  end

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(phase, mode == 2'(m_st), int'(mode), m_st);
      chk("R9", {low_iq, hyst, sw} == {m_st < 2, m_st >= 2, m_st == 3},
          int'({low_iq, hyst, sw}), int'({m_st < 2, m_st >= 2, m_st == 3}));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    chk("R1", mode == 2'd0 && low_iq && !hyst && !sw, int'(mode), 0);
    rst = 1'b0;
    wait_cyc(1);
    chk("R1", mode == 2'd0 && low_iq && !hyst && !sw, int'(mode), 0);
    // R2: short standby pulse, then a full window
    phase = "R2";
    l_rst = 1'b1; l_stby = 1'b1;
    wait_cyc(SF - 1); l_stby = 1'b0;
    wait_cyc(4);
    chk("R2", mode == 2'd0, int'(mode), 0);
    l_stby = 1'b1;
    wait_cyc(SF + 4);
    chk("R2", mode == 2'd1, int'(mode), 1);
    // R3: latch holds, reset flag clears it
    phase = "R3";
    l_stby = 1'b0;
    wait_cyc(5);
    chk("R3", mode == 2'd1, int'(mode), 1);
    l_rst = 1'b0; wait_cyc(1); l_rst = 1'b1;
    wait_cyc(2);
    chk("R3", mode == 2'd0, int'(mode), 0);
    l_stby = 1'b1;
    wait_cyc(SF + 4);
    // R4: short enable pulse with supply ready
    phase = "R4";
    v_off = 1'b1; v_on = 1'b1; wait_cyc(1); v_on = 1'b0;
    l_en = 1'b1; wait_cyc(EF - 1); l_en = 1'b0;
    wait_cyc(4);
    chk("R4", mode == 2'd1 && !hyst, int'(mode), 1);
    // R6: arming window then run
    phase = "R6";
    l_en = 1'b1;
    wait_cyc(EF + 2);
    chk("R6", mode == 2'd2 && hyst && !sw, int'(mode), 2);
    wait_cyc(SD);
    chk("R6", mode == 2'd3 && sw, int'(mode), 3);
    chk("R5", sw, int'(sw), 1);
    // R8: line enable lost
    phase = "R8";
    l_en = 1'b0;
    wait_cyc(3);
    chk("R8", mode == 2'd1 && !hyst, int'(mode), 1);
    l_en = 1'b1;
    wait_cyc(EF + SD + 4);
    // R7: supply drop mid-run
    phase = "R7";
    v_off = 1'b0; wait_cyc(1); v_off = 1'b1;
    wait_cyc(2);
    chk("R7", mode == 2'd1 && !sw && low_iq, int'(mode), 1);
    phase = "R5";
    wait_cyc(12);
    chk("R5", mode == 2'd1, int'(mode), 1);
    v_on = 1'b1; wait_cyc(1); v_on = 1'b0;
    wait_cyc(SD + 4);
    chk("R5", mode == 2'd3, int'(mode), 3);
    // R3: reset flag from run, with standby still set
    phase = "R3";
    l_rst = 1'b0;
    wait_cyc(3);
    chk("R3", mode == 2'd0 && low_iq && !sw, int'(mode), 0);
    wait_cyc(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule